// File: doc/BRIEF.md
# Fractional Prescaler Baud Tick Generator

This block makes the 16x sampling enable that paces a UART transmitter and receiver. It divides the input clock in two stages. The first is an optional fractional prescaler whose average ratio is M + N/8 clocks. The second is a 16-bit integer divisor. The output is a one-clock tick, so each baud bit spans sixteen ticks, and the baud rate is the input clock divided by 16 x divisor x prescale.

A simple write port sets the configuration. A write strobe carries a 2-bit address and an 8-bit data byte. Address 0 holds the divisor low byte and address 1 holds the divisor high byte. Address 2 holds the prescaler setting, with M in bits [7:3] and N in bits [2:0]. Bit 0 of address 3 selects the prescaler. A write to that select bit is accepted only while the enhanced-mode input is high.

A new divisor never cuts a period short. The divisor in use is reloaded only when a tick is issued. The period already under way finishes with the old value.

Top module: `baud_tick_gen`

## Requirements
- R1: The divisor D is the byte at address 0 plus 256 times the byte at address 1. With the prescaler deselected, consecutive tick16 pulses are exactly D clocks apart.
- R2: A divisor of 0 gives the same tick spacing as a divisor of 1.
- R3: Selecting the prescaler (address 3, bit 0 = 1) makes any 8 consecutive tick intervals sum to D x (8M + N) clocks, where M = byte[7:3] and N = byte[2:0] of address 2. While the prescaler is deselected, its setting has no effect and the spacing stays D.
- R4: With the prescaler selected, every single tick interval is either D x M + floor(D x N / 8) or D x M + ceil(D x N / 8) clocks.
- R5: An M of 0 is treated as M = 1.
- R6: Reset clears tick16, deselects the prescaler, sets the prescaler byte to 0x20 (M = 4, N = 0) and clears the divisor, so ticks come every clock. Selecting the prescaler without writing its byte then gives intervals of 4 x D.
- R7: A write to address 3 while enh_en is 0 leaves the prescaler selection unchanged. Dropping enh_en does not alter a selection that is already in place.
- R8: A divisor write takes effect at the next tick boundary. The period in progress keeps the old value. A write captured on the same edge as the terminal count governs the period that starts at that edge.
- R9: When the effective period is longer than one clock, tick16 is high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enh_en | input | 1 | Enhanced mode; allows writes to the prescaler select bit |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Register select: 0 divisor low, 1 divisor high, 2 prescaler, 3 control |
| wr_data | input | 8 | Write data |
| tick16 | output | 1 | Single-cycle 16x baud enable |

## Verification
Two events can land on the same clock edge: a divisor write and the terminal count that reloads the active divisor. The bench locks onto a steady tick train and times a low-byte write so that it is captured on exactly the edge where the next tick rises. It then checks that the tick still appears on time and that the very next interval already uses the new divisor. A second write, placed one clock after a boundary, must instead let one full old-length interval pass before the new spacing appears.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int          DIV_W   = 16,
  parameter logic [7:0]  PRE_RST = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enh_en,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       tick16
);
  localparam int HI_W = DIV_W - 8;

  logic [7:0]       div_lo;
  logic [HI_W-1:0]  div_hi;
  logic [7:0]       pre_reg;
  logic             psel;
  logic [DIV_W-1:0] div_act, div_next, deff, dcnt;
  logic [5:0]       meff, len, pcnt;
  logic [2:0]       acc;
  logic [3:0]       acc_sum;
  logic             pre_en, tc;

  wire wr_lo = wr_en && (wr_addr == 2'd0);
  wire wr_hi = wr_en && (wr_addr == 2'd1);

  assign div_next = {wr_hi ? wr_data[HI_W-1:0] : div_hi, wr_lo ? wr_data : div_lo};
  assign deff     = (div_act == '0) ? DIV_W'(1) : div_act;
  assign meff     = (pre_reg[7:3] == 5'd0) ? 6'd1 : {1'b0, pre_reg[7:3]};
  assign acc_sum  = {1'b0, acc} + {1'b0, pre_reg[2:0]};
  assign pre_en   = !psel || (pcnt == len - 6'd1);
  assign tc       = pre_en && (dcnt == deff - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lo  <= '0;
      div_hi  <= '0;
      pre_reg <= PRE_RST;
      psel    <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: div_lo  <= wr_data;
        2'd1: div_hi  <= wr_data[HI_W-1:0];
        2'd2: pre_reg <= wr_data;
        2'd3: if (enh_en) psel <= wr_data[0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      acc  <= '0;
      len  <= 6'd1;
    end else if (!psel) begin
      pcnt <= '0;
      acc  <= '0;
      len  <= meff;
    end else if (pre_en) begin
      pcnt <= '0;
      acc  <= acc_sum[2:0];
      len  <= meff + {5'd0, acc_sum[3]};
    end else begin
      pcnt <= pcnt + 6'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt    <= '0;
      div_act <= '0;
      tick16  <= 1'b0;
    end else begin
      tick16 <= tc;
      if (tc) begin
        dcnt    <= '0;
        div_act <= div_next;
      end else if (pre_en) begin
        dcnt <= dcnt + DIV_W'(1);
      end
    end
  end
endmodule

module baud_tick_gen_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enh_en,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic             tick16,
  input logic             psel,
  input logic             pre_en,
  input logic             tc,
  input logic [5:0]       pcnt,
  input logic [5:0]       len,
  input logic [DIV_W-1:0] dcnt,
  input logic [DIV_W-1:0] deff,
  input logic [DIV_W-1:0] div_act
);
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt < deff);

  assert_pre_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    psel |-> (pcnt < len));

  assert_ctrl_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3 && !enh_en) |=> $stable(psel));

  assert_ctrl_write_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 2'd3) |=> $stable(psel));

  assert_reload_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tc |=> $stable(div_act));

  assert_tick_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick16 |-> $past(pre_en));
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enh_en(enh_en), .wr_en(wr_en), .wr_addr(wr_addr),
  .tick16(tick16), .psel(psel), .pre_en(pre_en), .tc(tc), .pcnt(pcnt),
  .len(len), .dcnt(dcnt), .deff(deff), .div_act(div_act)
);

// File: tb/baud_tick_gen_test.sv
`timescale 1ns/1ps
module baud_tick_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enh_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       tick16;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  baud_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .enh_en(enh_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .tick16(tick16)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_div(input int d);
    wr(2'd0, d[7:0]);
    wr(2'd1, d[15:8]);
  endtask

  task automatic next_tick(input int start, output int gap);
    int c = start;
    do begin
      @(negedge clk);
      c++;
    end while (!tick16 && c < 100000);
    gap = c;
  endtask

  task automatic settle(input int n);
    int g;
    for (int i = 0; i < n; i++) next_tick(0, g);
  endtask

  task automatic check_plain(input int d, input int exp, input string req);
    int g;
    set_div(d);
    settle(3);
    for (int i = 0; i < 3; i++) begin
      next_tick(0, g);
      check(g == exp, req, g, exp);
    end
  endtask

  task automatic check_frac(input int d, input int m, input int n, input string req);
    int g, sum, me, lo, hi;
    me = (m == 0) ? 1 : m;
    wr(2'd2, 8'((m << 3) | n));
    set_div(d);
    settle(3);
    sum = 0;
    lo = d * me + (d * n) / 8;
    hi = d * me + (d * n + 7) / 8;
    for (int i = 0; i < 8; i++) begin
      next_tick(0, g);
      sum += g;
      check(g >= lo && g <= hi, "R4 single interval", g, lo);
    end
    check(sum == d * (8 * me + n), req, sum, d * (8 * me + n));
  endtask

  initial begin
    int g;
    #1;
    check(tick16 == 1'b0, "R6 tick low in reset", int'(tick16), 0);
    repeat (3) @(negedge clk);
    check(tick16 == 1'b0, "R6 tick low in reset", int'(tick16), 0);
    rst_n = 1'b1;
    settle(1);
    for (int i = 0; i < 4; i++) begin
      next_tick(0, g);
      check(g == 1, "R6 reset divisor spacing", g, 1);
    end

    for (int d = 1; d <= 24; d++) check_plain(d, d, "R1 integer spacing");
    check_plain(256, 256, "R1 high byte weight");
    check_plain(257, 257, "R1 both bytes");
    check_plain(300, 300, "R1 both bytes");
    check_plain(0, 1, "R2 zero divisor");

    check_plain(5, 5, "R9 setup");
    next_tick(0, g);
    @(negedge clk);
    check(tick16 == 1'b0, "R9 single cycle pulse", int'(tick16), 0);

    set_div(3);
    enh_en = 1'b0;
    wr(2'd3, 8'd1);
    settle(2);
    for (int i = 0; i < 3; i++) begin
      next_tick(0, g);
      check(g == 3, "R7 select ignored without enhanced mode", g, 3);
    end
    enh_en = 1'b1;
    wr(2'd3, 8'd1);
    settle(3);
    for (int i = 0; i < 3; i++) begin
      next_tick(0, g);
      check(g == 12, "R6 default prescale 4", g, 12);
    end
    enh_en = 1'b0;
    wr(2'd3, 8'd0);
    settle(2);
    for (int i = 0; i < 2; i++) begin
      next_tick(0, g);
      check(g == 12, "R7 select held when enhanced mode drops", g, 12);
    end
    enh_en = 1'b1;
    wr(2'd3, 8'd0);
    wr(2'd2, 8'h2D);
    check_plain(5, 5, "R3 prescaler bypassed when deselected");

    wr(2'd3, 8'd1);
    for (int d = 1; d <= 3; d++)
      for (int mi = 0; mi < 5; mi++)
        for (int n = 0; n < 8; n++) begin
          int m;
          m = (mi == 4) ? 7 : mi;
          check_frac(d, m, n, (m == 0) ? "R5 zero M as one" : "R3 eight-interval sum");
        end
    check_frac(1, 31, 7, "R3 largest M");
    check_frac(2, 31, 0, "R3 largest M");

    wr(2'd3, 8'd0);
    check_plain(6, 6, "R8 setup");
    next_tick(0, g);
    repeat (5) @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd9;
    @(negedge clk);
    wr_en = 1'b0;
    check(tick16 == 1'b1, "R8 boundary tick on time", int'(tick16), 1);
    next_tick(0, g);
    check(g == 9, "R8 same-edge write used at once", g, 9);
    next_tick(0, g);
    check(g == 9, "R8 new spacing holds", g, 9);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd4;
    @(negedge clk);
    wr_en = 1'b0;
    next_tick(1, g);
    check(g == 9, "R8 period in progress keeps old divisor", g, 9);
    next_tick(0, g);
    check(g == 4, "R8 new divisor after boundary", g, 4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule